// File: doc/BRIEF.md
# Dual-Speed Byte DMA Controller

This controller moves a programmed number of bytes between an 8-bit peripheral and a 16-bit memory port with no processor involvement. A single configuration write sets the direction, the speed class and the byte count, and it starts the transfer. In the slow class every byte is paced by a rising edge on the peripheral's request line. In the fast class the controller answers each byte it takes or presents with a one-cycle acknowledge pulse.

Bytes pass through a 32-entry byte buffer in both directions. This lets a fast peripheral keep streaming while the memory port is held off. When the buffer is full the acknowledge is withheld, so the peripheral stalls rather than losing data. On the memory side, byte pairs are packed into words with the first (even-address) byte in the upper half. A final odd byte travels alone in the upper half. When the count is exhausted and the buffer has drained, the block raises a done flag and a one-cycle interrupt pulse. Memory addressing is left to the memory controller.

Top module: `byte_dma`

## Requirements
- R1: A write with `cfg_we` high loads direction, speed and byte count and starts a transfer; exactly that many bytes cross the peripheral side, and no request after the last byte is acknowledged.
- R2: In slow mode (`cfg_fast`=0) one byte moves per rising edge of `per_req`; a request held high moves one byte only; `per_ack` stays 0.
- R3: In fast mode (`cfg_fast`=1) a byte moves in a cycle where `per_req` is high and `per_ack` is low, and `per_ack` is high for exactly the one cycle after each byte moved.
- R4: The buffer holds 32 bytes; with the memory port never granted, a fast peripheral-to-memory transfer is acknowledged exactly 32 times and then stalls until memory grants resume.
- R5: Memory words carry the earlier byte in bits 15:8 and the next in bits 7:0 with `mem_be`=2'b11; a final odd byte sits in bits 15:8 with `mem_be`=2'b10.
- R6: `mem_we` is 1 when `cfg_dir`=0 (peripheral to memory) and 0 when `cfg_dir`=1; a pending `mem_req` stays high with stable data, enables and direction until `mem_gnt`.
- R7: In the memory-to-peripheral direction, bytes appear on `per_dout` in memory order, upper half before lower half of each word; in fast mode the byte is valid while `per_ack` is high, and in slow mode from the cycle after the request edge.
- R8: `done` rises and `irq` pulses for one cycle once all bytes have reached their destination; a zero count finishes at once; `done` clears on the next configuration write.
- R9: After reset `per_ack`, `mem_req`, `busy`, `done` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe, starts a transfer |
| cfg_dir | input | 1 | 0: peripheral to memory, 1: memory to peripheral |
| cfg_fast | input | 1 | 0: request-paced slow mode, 1: acknowledged fast mode |
| cfg_count | input | CNT_W | Number of bytes to move |
| per_req | input | 1 | Peripheral request |
| per_din | input | 8 | Byte from peripheral |
| per_ack | output | 1 | Fast-mode byte acknowledge |
| per_dout | output | 8 | Byte to peripheral |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1: write to memory, 0: read |
| mem_be | output | 2 | Byte enables, bit 1 = upper half |
| mem_wdata | output | 16 | Word to memory |
| mem_gnt | input | 1 | Memory grant, completes the access this cycle |
| mem_rdata | input | 16 | Word from memory, valid with the grant |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer complete |
| irq | output | 1 | One-cycle completion pulse |

## Verification
A corrupt buffer pointer or occupancy count appears at the memory port within one word. The word data is wrong, the bytes are swapped, or a request is issued too early or too late. A full buffer that is misjudged shows up as a 33rd acknowledge, or as a stall that comes early, within the cycles in which the memory grant is held off. Miscounted remaining bytes show up only at the end of a transfer, as a missing or early `done` and `irq` or an extra acknowledge.

// File: rtl/byte_dma.sv
module byte_dma #(
  parameter int CNT_W = 16,
  parameter int DEPTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_dir,
  input  logic             cfg_fast,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             per_req,
  input  logic [7:0]       per_din,
  output logic             per_ack,
  output logic [7:0]       per_dout,
  output logic             mem_req,
  output logic             mem_we,
  output logic [1:0]       mem_be,
  output logic [15:0]      mem_wdata,
  input  logic             mem_gnt,
  input  logic [15:0]      mem_rdata,
  output logic             busy,
  output logic             done,
  output logic             irq
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);
  localparam logic [AW:0] ONE = (AW+1)'(1);
  localparam logic [AW:0] TWO = (AW+1)'(2);

  logic active_q, out_q, fast_q, done_q, irq_q, pend_q, req_q, ack_q;
  logic [CNT_W-1:0] per_rem, mem_rem;
  logic [7:0] fifo [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0] cnt;
  logic [7:0] dout_q;

  logic last_half, rise, per_can, per_fire, mem_fire, finish;
  logic [AW-1:0] wp1, rp1;
  logic [AW:0] need, free_n, push_n, pop_n;

  assign wp1       = wp + AW'(1);
  assign rp1       = rp + AW'(1);
  assign last_half = (mem_rem == CNT_W'(1));
  assign need      = last_half ? ONE : TWO;
  assign free_n    = FULL - cnt;
  assign rise      = per_req && !req_q;

  assign mem_req  = active_q && (mem_rem != '0) && (out_q ? (free_n >= need) : (cnt >= need));
  assign mem_fire = mem_req && mem_gnt;
  assign per_can  = active_q && (per_rem != '0) && (out_q ? (cnt != '0) : (cnt != FULL));
  assign per_fire = per_can && (fast_q ? (per_req && !ack_q) : (pend_q || rise));
  assign finish   = active_q && (per_rem == '0) && (mem_rem == '0);

  assign push_n = out_q ? (mem_fire ? need : '0) : (per_fire ? ONE : '0);
  assign pop_n  = out_q ? (per_fire ? ONE : '0) : (mem_fire ? need : '0);

  assign mem_wdata = {fifo[rp], last_half ? 8'h00 : fifo[rp1]};
  assign mem_be    = last_half ? 2'b10 : 2'b11;
  assign mem_we    = !out_q;
  assign per_ack   = ack_q;
  assign per_dout  = dout_q;
  assign busy      = active_q;
  assign done      = done_q;
  assign irq       = irq_q;

  always_ff @(posedge clk) begin
    if (per_fire && !out_q) fifo[wp] <= per_din;
    if (mem_fire && out_q) begin
      fifo[wp] <= mem_rdata[15:8];
      if (!last_half) fifo[wp1] <= mem_rdata[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0; out_q <= 1'b0; fast_q <= 1'b0;
      done_q <= 1'b0; irq_q <= 1'b0; pend_q <= 1'b0;
      req_q <= 1'b0; ack_q <= 1'b0; dout_q <= 8'h00;
      per_rem <= '0; mem_rem <= '0;
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      req_q <= per_req;
      if (cfg_we) begin
        active_q <= 1'b1; out_q <= cfg_dir; fast_q <= cfg_fast;
        per_rem <= cfg_count; mem_rem <= cfg_count;
        wp <= '0; rp <= '0; cnt <= '0;
        done_q <= 1'b0; irq_q <= 1'b0; pend_q <= 1'b0; ack_q <= 1'b0;
      end else begin
        wp <= wp + AW'(push_n);
        rp <= rp + AW'(pop_n);
        cnt <= cnt + push_n - pop_n;
        per_rem <= per_rem - CNT_W'(per_fire);
        mem_rem <= mem_rem - (mem_fire ? CNT_W'(need) : '0);
        ack_q <= fast_q && per_fire;
        pend_q <= !fast_q && active_q && (pend_q || rise) && !per_fire;
        if (per_fire && out_q) dout_q <= fifo[rp];
        irq_q <= finish;
        if (finish) begin
          active_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  // R4
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);

  // R3
  ack_fast_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_ack |-> fast_q);

  // R3
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_ack |=> !per_ack);

  // R6
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt && !cfg_we && out_q == 1'b0) |=>
      (mem_req && $stable(mem_wdata) && $stable(mem_be) && $stable(mem_we)));

  // R8
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R8
  done_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cnt == '0 && !mem_req && !busy));
endmodule

// File: tb/test_byte_dma.sv
module test_byte_dma;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_dir = 1'b0, cfg_fast = 1'b0;
  logic [15:0] cfg_count = '0;
  logic per_req = 1'b0;
  logic [7:0] per_din = '0;
  logic per_ack, mem_req, mem_we, busy, done, irq;
  logic [7:0] per_dout;
  logic [1:0] mem_be;
  logic [15:0] mem_wdata, mem_rdata;
  logic gnt_en = 1'b0;
  logic ma_clr = 1'b0;
  int ma;
  logic [15:0] mdata [64];
  logic [1:0] last_be;
  logic last_we;
  int tests = 0, fails = 0;
  int irq_cnt = 0, ack_cnt = 0;

  always #10 clk = ~clk;

  byte_dma i_byte_dma (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dir(cfg_dir), .cfg_fast(cfg_fast),
    .cfg_count(cfg_count), .per_req(per_req), .per_din(per_din), .per_ack(per_ack),
    .per_dout(per_dout), .mem_req(mem_req), .mem_we(mem_we), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_gnt(gnt_en), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .irq(irq));

  assign mem_rdata = {8'(8'h40 + 2*ma), 8'(8'h41 + 2*ma)};

  always @(posedge clk) begin
    if (ma_clr) ma <= 0;
    else if (mem_req && gnt_en) begin
      if (mem_we) mdata[ma % 64] <= mem_wdata;
      last_be <= mem_be;
      last_we <= mem_we;
      ma <= ma + 1;
    end
  end

  always @(negedge clk) begin
    if (irq) irq_cnt++;
    if (per_ack) ack_cnt++;
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic start(input logic dir, input logic fast, input int n);
    @(negedge clk);
    cfg_dir = dir; cfg_fast = fast; cfg_count = 16'(n); cfg_we = 1'b1; ma_clr = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; ma_clr = 1'b0;
  endtask

  task automatic wait_done(input int tmo);
    for (int k = 0; k < tmo && !done; k++) @(negedge clk);
  endtask

  task automatic feed(input logic [7:0] v, input int tmo, output bit ok);
    per_din = v; per_req = 1'b1; ok = 1'b0;
    for (int k = 0; k < tmo && !ok; k++) begin
      @(negedge clk);
      if (per_ack) ok = 1'b1;
    end
  endtask

  task automatic fetch(input int tmo, output bit ok, output logic [7:0] b);
    per_req = 1'b1; ok = 1'b0; b = '0;
    for (int k = 0; k < tmo && !ok; k++) begin
      @(negedge clk);
      if (per_ack) begin ok = 1'b1; b = per_dout; end
    end
  endtask

  task automatic t_reset;
    check(!per_ack && !mem_req && !busy && !done && !irq, "R9", "reset outputs",
          {per_ack, mem_req, busy, done, irq}, 0);
  endtask

  task automatic t_fast_in;
    int i0, a0; bit ok;
    gnt_en = 1'b1; i0 = irq_cnt; a0 = ack_cnt;
    start(1'b0, 1'b1, 6);
    check(busy, "R1", "busy after config", busy, 1);
    for (int i = 0; i < 6; i++) begin
      feed(8'(i*8'h11 + 8'h03), 10, ok);
      check(ok, "R3", "fast ack for byte", ok, 1);
    end
    feed(8'hEE, 10, ok);
    check(!ok, "R1", "no ack past count", ok, 0);
    per_req = 1'b0;
    wait_done(50);
    check(done, "R8", "done fast in", done, 1);
    check(irq_cnt - i0 == 1, "R8", "one irq pulse", irq_cnt - i0, 1);
    check(ack_cnt - a0 == 6, "R3", "ack count", ack_cnt - a0, 6);
    for (int w = 0; w < 3; w++)
      check(mdata[w] == {8'(2*w*8'h11 + 8'h03), 8'((2*w+1)*8'h11 + 8'h03)}, "R5", "packed word",
            mdata[w], {8'(2*w*8'h11 + 8'h03), 8'((2*w+1)*8'h11 + 8'h03)});
    check(last_be == 2'b11, "R5", "full word enables", last_be, 3);
    check(last_we == 1'b1, "R6", "write direction", last_we, 1);
    check(ma == 3, "R1", "word count", ma, 3);
  endtask

  task automatic t_odd_in;
    bit ok;
    gnt_en = 1'b1;
    start(1'b0, 1'b1, 5);
    for (int i = 0; i < 5; i++) feed(8'(8'hC0 ^ i), 10, ok);
    per_req = 1'b0;
    wait_done(50);
    check(done, "R8", "done odd", done, 1);
    check(mdata[2] == 16'hC400, "R5", "odd tail in upper half", mdata[2], 16'hC400);
    check(last_be == 2'b10, "R5", "odd tail enables", last_be, 2);
    check(mdata[1] == 16'hC2C3, "R5", "middle word", mdata[1], 16'hC2C3);
  endtask

  task automatic t_full;
    int got; bit ok;
    gnt_en = 1'b0; got = 0;
    start(1'b0, 1'b1, 40);
    for (int i = 0; i < 40 && got == i; i++) begin
      feed(8'(i), 10, ok);
      if (ok) got++;
    end
    check(got == 32, "R4", "acks before stall", got, 32);
    check(mem_req && ma == 0, "R4", "memory held, request pending", ma, 0);
    gnt_en = 1'b1;
    for (int i = got; i < 40; i++) begin
      feed(8'(i), 20, ok);
      check(ok, "R4", "resume after drain", ok, 1);
    end
    per_req = 1'b0;
    wait_done(60);
    check(done, "R4", "done after stall", done, 1);
    for (int w = 0; w < 20; w++)
      if (mdata[w] != {8'(2*w), 8'(2*w+1)})
        check(1'b0, "R4", "stalled data", mdata[w], {8'(2*w), 8'(2*w+1)});
    check(mdata[19] == 16'h2627, "R4", "last word", mdata[19], 16'h2627);
  endtask

  task automatic t_slow_in;
    int a0;
    gnt_en = 1'b1; a0 = ack_cnt;
    start(1'b0, 1'b0, 3);
    per_din = 8'h5A; per_req = 1'b1;
    repeat (8) @(negedge clk);
    per_req = 1'b0; repeat (2) @(negedge clk);
    per_din = 8'h6B; per_req = 1'b1; @(negedge clk); per_req = 1'b0;
    repeat (4) @(negedge clk);
    check(!done, "R2", "held request moved one byte", done, 0);
    per_din = 8'h7C; per_req = 1'b1; @(negedge clk); per_req = 1'b0;
    wait_done(20);
    check(done, "R2", "slow in completes", done, 1);
    check(mdata[0] == 16'h5A6B, "R2", "slow word", mdata[0], 16'h5A6B);
    check(mdata[1] == 16'h7C00 && last_be == 2'b10, "R5", "slow odd tail", mdata[1], 16'h7C00);
    check(ack_cnt == a0, "R2", "no ack in slow mode", ack_cnt - a0, 0);
  endtask

  task automatic t_fast_out;
    bit ok; logic [7:0] b;
    gnt_en = 1'b1;
    start(1'b1, 1'b1, 5);
    for (int i = 0; i < 5; i++) begin
      fetch(10, ok, b);
      check(ok && b == 8'(8'h40 + i), "R7", "fast out byte", b, 8'(8'h40 + i));
    end
    per_req = 1'b0;
    check(last_we == 1'b0, "R6", "read direction", last_we, 0);
    wait_done(20);
    check(done && ma == 3, "R8", "fast out done", ma, 3);
  endtask

  task automatic t_slow_out;
    int a0;
    gnt_en = 1'b1; a0 = ack_cnt;
    start(1'b1, 1'b0, 3);
    repeat (5) @(negedge clk);
    check(!done && busy, "R2", "waits for request", done, 0);
    for (int i = 0; i < 3; i++) begin
      per_req = 1'b1; @(negedge clk); per_req = 1'b0;
      check(per_dout == 8'(8'h40 + i), "R7", "slow out byte", per_dout, 8'(8'h40 + i));
      repeat (2) @(negedge clk);
    end
    wait_done(20);
    check(done, "R8", "slow out done", done, 1);
    check(ack_cnt == a0, "R2", "no ack slow out", ack_cnt - a0, 0);
  endtask

  task automatic t_zero;
    int i0;
    i0 = irq_cnt;
    start(1'b0, 1'b1, 0);
    check(!done, "R8", "done cleared by config", done, 0);
    repeat (3) @(negedge clk);
    check(done && irq_cnt - i0 == 1, "R8", "zero count finishes", irq_cnt - i0, 1);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_fast_in();
    t_odd_in();
    t_full();
    t_slow_in();
    t_fast_out();
    t_slow_out();
    t_zero();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule